// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter with Master Clock Generation

The block runs as the clock master of a two-channel serial audio link. From one master clock it derives a bit clock and a frame clock. It then shifts two 24-bit two's complement samples, left channel first and MSB first, onto a single data line. Every frame holds 64 bit clocks, split into two 32-slot halves. Each half carries 24 data bits, and the unused slots are driven low. A two-bit speed code selects single, double or quad rate, which changes how far the master clock is divided down. A prescale input halves the master clock ahead of every other divider. A format input selects left-justified or I2S framing.

The whole block runs in one clock domain. `clk_i` runs at twice the master clock rate, so one master-clock period lasts two `clk_i` cycles. This lets the bit clock toggle as fast as the master clock while staying a plain register output. The user writes a sample pair with `load_i` into a holding register. At each frame start the block copies the holding register into the shifter and pulses `req_o`, which invites the next pair.

Top module: `asp_master_tx`

## Requirements
- R1: Speed code 00 (single) gives a bit-clock period of 8 `clk_i` cycles (divide 4 of the master clock), code 01 (double) gives 4 cycles and code 10 (quad) gives 2 cycles, so in quad rate the bit clock equals the master clock.
- R2: With `prediv_i`=1 every bit-clock and frame-clock period is twice as long as with `prediv_i`=0.
- R3: A frame spans 64 bit-clock periods. The frame clock holds one level for bit-clock slots 0 to 31 and the opposite level for slots 32 to 63, so its period is 256, 128 or 64 master clocks in single, double or quad rate.
- R4: With `fmt_i`=0 (left-justified) the frame clock is high during the left half. The left sample's MSB occupies slot 0 and the right sample's MSB occupies slot 32.
- R5: With `fmt_i`=1 (I2S) the frame clock is low during the left half. Each MSB comes one slot after the frame-clock edge, in slot 1 for left and slot 33 for right.
- R6: Every slot of a half-frame that carries no sample bit drives the data line low.
- R7: The frame clock and the data line change only together with a falling edge of the bit clock.
- R8: `load_i` captures `left_i`/`right_i` into a holding register. The frame starting at slot 0 transmits the holding contents, and `req_o` pulses for one `clk_i` cycle at that frame start, exactly once per frame.
- R9: Speed code 11 is reserved. While it is applied, the bit clock, frame clock, data line and `req_o` stay low.
- R10: During reset the bit clock, frame clock, data line and `req_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock at twice the master clock rate |
| rst_ni | input | 1 | Active-low asynchronous reset |
| speed_i | input | 2 | Speed code: 00 single, 01 double, 10 quad, 11 reserved |
| prediv_i | input | 1 | Halve the master clock before all dividers |
| fmt_i | input | 1 | 0 left-justified, 1 I2S |
| load_i | input | 1 | Capture the sample pair into the holding register |
| left_i | input | 24 | Left sample, two's complement |
| right_i | input | 24 | Right sample, two's complement |
| lrck_o | output | 1 | Frame clock |
| sclk_o | output | 1 | Bit clock |
| sdata_o | output | 1 | Serial data |
| req_o | output | 1 | One-cycle pulse at each frame start |

## Verification
After reset is released, the bit clock first rises after h `clk_i` cycles, where h is half a bit-clock period. Slot 0 and the `req_o` pulse arrive on the same edge, 2h cycles after release. Each later slot starts 2h cycles after the one before. The bench therefore times nothing absolutely. It samples every output on the falling edge of `clk_i`, finds bit-clock rising edges as a receiver would, throws away the single rise that comes before slot 0, and reads the frame clock and data at each of the next 64 rises. The bit-clock period comes from the cycle distance between two consecutive rises. `req_o` is counted over the same window.

// File: rtl/asp_pkg.sv
package asp_pkg;
  typedef enum logic [1:0] {
    SPD_SINGLE = 2'b00,
    SPD_DOUBLE = 2'b01,
    SPD_QUAD   = 2'b10,
    SPD_RSVD   = 2'b11
  } speed_e;

  localparam int unsigned HALF_W = 4;

  // clk_i cycles per bit-clock half period
  function automatic logic [HALF_W-1:0] half_cycles(speed_e spd, logic pre);
    logic [HALF_W-1:0] base;
    case (spd)
      SPD_SINGLE: base = HALF_W'(4);
      SPD_DOUBLE: base = HALF_W'(2);
      default:    base = HALF_W'(1);
    endcase
    return pre ? (base << 1) : base;
  endfunction
endpackage

// File: rtl/asp_timebase.sv
module asp_timebase
  import asp_pkg::*;
#(
  parameter int unsigned SLOT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  speed_e            speed_i,
  input  logic              pre_i,
  output logic              sclk_o,
  output logic              fall_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [SLOT_W-1:0] slot_d_o
);
  logic [HALF_W-1:0] cnt_q, half;
  logic [SLOT_W-1:0] slot_q;
  logic              sclk_q, term, rsvd;

  assign half     = half_cycles(speed_i, pre_i);
  assign rsvd     = (speed_i == SPD_RSVD);
  assign term     = (cnt_q >= half - HALF_W'(1));
  assign fall_o   = term && sclk_q && !rsvd;
  assign slot_d_o = fall_o ? slot_q + SLOT_W'(1) : slot_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
      slot_q <= '1;
    end else if (rsvd) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
      slot_q <= '1;
    end else if (term) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
      slot_q <= slot_d_o;
    end else begin
      cnt_q  <= cnt_q + HALF_W'(1);
    end
  end

  assign sclk_o = sclk_q;
  assign slot_o = slot_q;

  // R3: slot index only advances on a bit-clock fall
  a_r3_slot_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rsvd && $past(!rsvd) && $changed(slot_q)) |-> $fell(sclk_q));

  // R9: reserved code parks the bit clock low
  a_r9_sclk_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd |=> !sclk_q);
endmodule

// File: rtl/asp_serializer.sv
module asp_serializer #(
  parameter int unsigned DW     = 24,
  parameter int unsigned SLOT_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fmt_i,
  input  logic              rsvd_i,
  input  logic              fall_i,
  input  logic              sclk_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [SLOT_W-1:0] slot_d_i,
  input  logic              load_i,
  input  logic [DW-1:0]     left_i,
  input  logic [DW-1:0]     right_i,
  output logic              lrck_o,
  output logic              sd_o,
  output logic              req_o
);
  localparam int unsigned POS_W = SLOT_W - 1;
  localparam int unsigned NCH   = 2;

  logic [DW-1:0] hold_q  [NCH];
  logic [DW-1:0] frame_q [NCH];
  logic [DW-1:0] in_w    [NCH];
  logic [DW-1:0] src     [NCH];
  logic [POS_W-1:0] pos;
  logic          chan, frame_start, bit_ok, bit_d, lrck_d, lrck_q, sd_q, req_q;
  int unsigned   k;

  assign in_w[0] = left_i;
  assign in_w[1] = right_i;

  assign pos         = slot_d_i[POS_W-1:0];
  assign chan        = slot_d_i[SLOT_W-1];
  assign frame_start = (slot_d_i == '0);

  generate
    for (genvar c = 0; c < NCH; c++) begin : g_ch
      assign src[c] = frame_start ? hold_q[c] : frame_q[c];

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          hold_q[c]  <= '0;
          frame_q[c] <= '0;
        end else begin
          if (load_i) hold_q[c] <= in_w[c];
          if (fall_i && frame_start) frame_q[c] <= hold_q[c];
        end
      end
    end
  endgenerate

  always_comb begin
    // I2S shifts every bit one slot later
    if (fmt_i) begin
      bit_ok = (int'(pos) >= 1) && (int'(pos) <= int'(DW));
      k      = bit_ok ? int'(pos) - 1 : 0;
    end else begin
      bit_ok = (int'(pos) < int'(DW));
      k      = bit_ok ? int'(pos) : 0;
    end
    bit_d  = bit_ok && src[chan][DW-1-k];
    lrck_d = fmt_i ? chan : ~chan;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lrck_q <= 1'b0;
      sd_q   <= 1'b0;
      req_q  <= 1'b0;
    end else if (rsvd_i) begin
      lrck_q <= 1'b0;
      sd_q   <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      req_q <= fall_i && frame_start;
      if (fall_i) begin
        lrck_q <= lrck_d;
        sd_q   <= bit_d;
      end
    end
  end

  assign lrck_o = lrck_q;
  assign sd_o   = sd_q;
  assign req_o  = req_q;

  // R7: frame clock moves only with a bit-clock fall
  a_r7_lrck_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!rsvd_i) && $changed(lrck_q)) |-> $fell(sclk_i));

  // R7: data moves only with a bit-clock fall
  a_r7_data_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(!rsvd_i) && $changed(sd_q)) |-> $fell(sclk_i));

  // R8: request pulse coincides with slot 0
  a_r8_req_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q |-> (slot_i == '0) && $fell(sclk_i));

  // R6: trailing slots of each half are low
  a_r6_pad_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(slot_i[POS_W-1:0]) > int'(DW)) |-> !sd_q);

  // R9: reserved code silences frame clock, data and request
  a_r9_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsvd_i |=> (!lrck_q && !sd_q && !req_q));
endmodule

// File: rtl/asp_master_tx.sv
module asp_master_tx
  import asp_pkg::*;
#(
  parameter int unsigned SAMPLE_W = 24,
  parameter int unsigned SLOTS    = 64
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          speed_i,
  input  logic                prediv_i,
  input  logic                fmt_i,
  input  logic                load_i,
  input  logic [SAMPLE_W-1:0] left_i,
  input  logic [SAMPLE_W-1:0] right_i,
  output logic                lrck_o,
  output logic                sclk_o,
  output logic                sdata_o,
  output logic                req_o
);
  localparam int unsigned SLOT_W = $clog2(SLOTS);

  speed_e            spd;
  logic              fall, sclk;
  logic [SLOT_W-1:0] slot, slot_d;

  assign spd = speed_e'(speed_i);

  asp_timebase #(.SLOT_W(SLOT_W)) u_tb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .speed_i  (spd),
    .pre_i    (prediv_i),
    .sclk_o   (sclk),
    .fall_o   (fall),
    .slot_o   (slot),
    .slot_d_o (slot_d)
  );

  asp_serializer #(.DW(SAMPLE_W), .SLOT_W(SLOT_W)) u_ser (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fmt_i    (fmt_i),
    .rsvd_i   (spd == SPD_RSVD),
    .fall_i   (fall),
    .sclk_i   (sclk),
    .slot_i   (slot),
    .slot_d_i (slot_d),
    .load_i   (load_i),
    .left_i   (left_i),
    .right_i  (right_i),
    .lrck_o   (lrck_o),
    .sd_o     (sdata_o),
    .req_o    (req_o)
  );

  assign sclk_o = sclk;
endmodule

// File: tb/asp_master_tx_tb.sv
module asp_master_tx_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 6;

  // {speed, prediv, fmt, left, right}
  localparam logic [51:0] VEC [NVEC] = '{
    {2'b00, 1'b0, 1'b0, 24'hA5C3F1, 24'h3C0F96},
    {2'b01, 1'b0, 1'b1, 24'h800001, 24'h7FFFFE},
    {2'b10, 1'b0, 1'b0, 24'hFFFFFF, 24'h000001},
    {2'b10, 1'b1, 1'b1, 24'h123456, 24'hFEDCBA},
    {2'b00, 1'b1, 1'b1, 24'h5A5A5A, 24'hC00003},
    {2'b01, 1'b1, 1'b0, 24'h0F0F0F, 24'h800000}
  };

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  speed = 2'b00;
  logic        prediv = 1'b0, fmt = 1'b0, load = 1'b0;
  logic [23:0] left = '0, right = '0;
  logic        lrck_o, sclk_o, sdata_o, req_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asp_master_tx u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .speed_i(speed), .prediv_i(prediv),
    .fmt_i(fmt), .load_i(load), .left_i(left), .right_i(right),
    .lrck_o(lrck_o), .sclk_o(sclk_o), .sdata_o(sdata_o), .req_o(req_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run_vec(input logic [1:0] md, input logic pr, input logic fm,
                         input logic [23:0] lv, input logic [23:0] rv);
    int h, cyc, rises, t1, t2, reqs, lr_err, pad_err, off;
    logic bitv [64];
    logic lrv  [64];
    logic prev, lvl;
    logic [23:0] lw, rw;
    h = (md == 2'b00) ? 4 : (md == 2'b01) ? 2 : 1;
    if (pr) h = h * 2;
    rst_ni = 1'b0; speed = md; prediv = pr; fmt = fm;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1; load = 1'b1; left = lv; right = rv;
    prev = 1'b0; rises = -1; cyc = 0; t1 = 0; t2 = 0; reqs = 0;
    while (rises < 64 && cyc < 4000) begin
      @(negedge clk);
      cyc++;
      if (cyc == 1) load = 1'b0;
      if (req_o && rises >= 0) reqs++;
      if (sclk_o && !prev) begin
        rises++;
        if (rises == 1) t1 = cyc;
        if (rises == 2) t2 = cyc;
        if (rises >= 1) begin
          bitv[rises-1] = sdata_o;
          lrv[rises-1]  = lrck_o;
        end
      end
      prev = sclk_o;
    end
    chk(rises == 64, "R1 bit clock running", rises, 64);
    if (rises == 64) begin
      chk((t2 - t1) == 2*h, pr ? "R2 prescaled bit-clock period" : "R1 bit-clock period",
          t2 - t1, 2*h);
      lvl = fm ? 1'b0 : 1'b1;
      lr_err = 0;
      for (int k = 0; k < 64; k++)
        if (lrv[k] !== ((k < 32) ? lvl : ~lvl)) lr_err++;
      chk(lr_err == 0, fm ? "R5 R3 frame clock levels" : "R4 R3 frame clock levels", lr_err, 0);
      off = fm ? 1 : 0;
      for (int k = 0; k < 24; k++) begin
        lw[23-k] = bitv[k+off];
        rw[23-k] = bitv[32+k+off];
      end
      chk(lw == lv, fm ? "R5 R8 left word" : "R4 R8 left word", lw, lv);
      chk(rw == rv, fm ? "R5 R8 right word" : "R4 R8 right word", rw, rv);
      pad_err = 0;
      for (int k = 0; k < 32; k++)
        if ((k < off || k >= 24 + off) && (bitv[k] !== 1'b0 || bitv[32+k] !== 1'b0)) pad_err++;
      chk(pad_err == 0, "R6 unused slots low", pad_err, 0);
      chk(reqs == 1, "R8 one request per frame", reqs, 1);
    end
  endtask

  initial begin
    int bad;
    // R10: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk({sclk_o, lrck_o, sdata_o, req_o} == 4'b0, "R10 reset outputs low",
        {sclk_o, lrck_o, sdata_o, req_o}, 0);

    for (int v = 0; v < NVEC; v++)
      run_vec(VEC[v][51:50], VEC[v][49], VEC[v][48], VEC[v][47:24], VEC[v][23:0]);

    // R9: reserved code keeps everything still
    rst_ni = 1'b0; speed = 2'b11; prediv = 1'b0; fmt = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_ni = 1'b1; load = 1'b1; left = 24'hFFFFFF; right = 24'hFFFFFF;
    @(negedge clk);
    load = 1'b0;
    bad = 0;
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      if (sclk_o || lrck_o || sdata_o || req_o) bad++;
    end
    chk(bad == 0, "R9 reserved code static low", bad, 0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule